// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets two processors raise interrupts on each other through 32-bit doorbell words. Three channels are provided: a low-priority channel and a high-priority channel that any agent may use, and a third channel that only a secure agent may touch. Each channel holds two doorbell words, one for the receive direction and one for the transmit direction. Every word can be read as a status register, and it can be modified bit by bit through a write-one-to-set register and a write-one-to-clear register.

A sender rings a doorbell by writing ones to the set register of the peer's word. The peer sees its interrupt rise, reads the status, and writes the value it read to the clear register. The sender polls the same status until it reads zero, and treats that as the end of the transfer. Each of the six words drives its own interrupt line, which is high whenever any bit of that word is one.

The bus port is a simple zero-wait register slave. A non-secure access that lands anywhere in the secure channel's two register windows is refused: it reads zero, it changes nothing, and it flags an error in the same cycle.

Top module: `dbell_mbox`

## Requirements
- R1: After reset every doorbell word is zero and all six interrupt lines are low.
- R2: A write to a set register (word offset 0x08) turns on every status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to a clear register (word offset 0x10) turns off every status bit whose write-data bit is 1. Bits written as 0 keep their value, so a write of zero changes nothing.
- R4: A read of a set or clear register returns zero.
- R5: The interrupt of a word is high exactly when that word has at least one bit set. irq_rx[c] follows the receive word of channel c and irq_tx[c] follows its transmit word (c = 0 low priority, 1 high priority, 2 secure). Words do not affect one another.
- R6: The receive status registers are at 0x000, 0x020 and 0x200 for channels 0, 1 and 2. Each transmit word sits 0x100 above the receive word of its channel. Within a word, status is at offset 0x00, set at 0x08 and clear at 0x10.
- R7: Any other address reads zero and ignores writes. Such an access does not raise bus_err.
- R8: When bus_secure is 0, an access to any address in 0x200–0x21F or 0x300–0x31F reads zero, changes no state, and drives bus_err high in that cycle.
- R9: When bus_secure is 1, the secure channel behaves like the other channels, and bus_err stays low.
- R10: bus_ready equals bus_sel in the same cycle. Read data and bus_err are valid in the cycle in which bus_sel is high, and a write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 = the access comes from a secure agent |
| bus_rdata | output | 32 | Read data, zero when no status register is read |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_err | output | 1 | Non-secure access to the secure channel was refused |
| irq_rx | output | 3 | Per-channel receive-word interrupt |
| irq_tx | output | 3 | Per-channel transmit-word interrupt |

## Verification
The assertions assume a single-port master that holds bus_sel, bus_wr, bus_addr, bus_wdata and bus_secure steady for one whole clock period. They also assume that interrupt edges come only from bus writes, since no other agent can modify the doorbell words. The bench drives every access at the falling edge and releases it just after the next rising edge. It uses only word-aligned addresses, with mapped, hole and out-of-range cases mixed in. A behavioural model of the six words checks the read data, ready, error and all interrupt lines in every cycle.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
   localparam int unsigned DBM_NCH    = 3;
   localparam int unsigned DBM_NSETS  = 2 * DBM_NCH;
   localparam int unsigned DBM_SECCH  = 2;

   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_STAT = 2'd1,
      KIND_SET  = 2'd2,
      KIND_CLR  = 2'd3
   } dbm_kind_e;
endpackage

// File: rtl/dbm_decode.sv
module dbm_decode
   import dbm_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_LP   = 'h000,
   parameter int unsigned BASE_HP   = 'h020,
   parameter int unsigned BASE_SEC  = 'h200,
   parameter int unsigned TX_STRIDE = 'h100,
   parameter int unsigned OFS_STAT  = 'h00,
   parameter int unsigned OFS_SET   = 'h08,
   parameter int unsigned OFS_CLR   = 'h10,
   parameter int unsigned WIN       = 'h20
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 secure,
   output logic [DBM_NSETS-1:0] set_hit,
   output dbm_kind_e            kind,
   output logic                 blocked
);
   function automatic int unsigned set_base(input int unsigned s);
      int unsigned b;
      case (s / 2)
         0:       b = BASE_LP;
         1:       b = BASE_HP;
         default: b = BASE_SEC;
      endcase
      return b + (s % 2) * TX_STRIDE;
   endfunction

   logic in_sec_win;

   always_comb begin
      set_hit    = '0;
      kind       = KIND_NONE;
      in_sec_win = 1'b0;
      for (int unsigned s = 0; s < DBM_NSETS; s++) begin
         if (int'(addr) == set_base(s) + OFS_STAT) begin
            set_hit[s] = 1'b1;
            kind       = KIND_STAT;
         end
         if (int'(addr) == set_base(s) + OFS_SET) begin
            set_hit[s] = 1'b1;
            kind       = KIND_SET;
         end
         if (int'(addr) == set_base(s) + OFS_CLR) begin
            set_hit[s] = 1'b1;
            kind       = KIND_CLR;
         end
         if ((s / 2) == DBM_SECCH &&
             int'(addr) >= set_base(s) && int'(addr) < set_base(s) + WIN)
            in_sec_win = 1'b1;
      end
      blocked = in_sec_win & ~secure;
      if (blocked) begin
         set_hit = '0;
         kind    = KIND_NONE;
      end
   end
endmodule

// File: rtl/dbm_bell.sv
module dbm_bell #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] status,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_mask) | set_mask;
   end

   assign irq = |status;
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
   import dbm_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_LP   = 'h000,
   parameter int unsigned BASE_HP   = 'h020,
   parameter int unsigned BASE_SEC  = 'h200,
   parameter int unsigned TX_STRIDE = 'h100,
   parameter int unsigned WIN       = 'h20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_secure,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  bus_ready,
   output logic                  bus_err,
   output logic [DBM_NCH-1:0]    irq_rx,
   output logic [DBM_NCH-1:0]    irq_tx
);
   localparam int unsigned SPAN = BASE_SEC + TX_STRIDE + WIN;

   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $fatal(1, "dbell_mbox: DATA_W out of range");
   end
   if (SPAN > (1 << ADDR_W)) begin : g_bad_map
      $fatal(1, "dbell_mbox: register map exceeds address space");
   end
   if (WIN < 'h18) begin : g_bad_win
      $fatal(1, "dbell_mbox: window too small for three registers");
   end

   logic [DBM_NSETS-1:0] set_hit;
   dbm_kind_e            kind;
   logic                 blocked;
   logic [DATA_W-1:0]    status [DBM_NSETS];
   logic [DBM_NSETS-1:0] irq_set;

   dbm_decode #(
      .ADDR_W   (ADDR_W),
      .BASE_LP  (BASE_LP),
      .BASE_HP  (BASE_HP),
      .BASE_SEC (BASE_SEC),
      .TX_STRIDE(TX_STRIDE),
      .OFS_STAT ('h00),
      .OFS_SET  ('h08),
      .OFS_CLR  ('h10),
      .WIN      (WIN)
   ) u_dec (
      .addr   (bus_addr),
      .secure (bus_secure),
      .set_hit(set_hit),
      .kind   (kind),
      .blocked(blocked)
   );

   logic do_wr;
   assign do_wr = bus_sel & bus_wr;

   for (genvar s = 0; s < DBM_NSETS; s++) begin : g_set
      logic [DATA_W-1:0] set_m, clr_m;
      assign set_m = (do_wr && set_hit[s] && kind == KIND_SET) ? bus_wdata : '0;
      assign clr_m = (do_wr && set_hit[s] && kind == KIND_CLR) ? bus_wdata : '0;

      dbm_bell #(.DATA_W(DATA_W)) u_bell (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_mask(set_m),
         .clr_mask(clr_m),
         .status  (status[s]),
         .irq     (irq_set[s])
      );
   end

   for (genvar c = 0; c < DBM_NCH; c++) begin : g_irq
      assign irq_rx[c] = irq_set[2*c];
      assign irq_tx[c] = irq_set[2*c+1];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && kind == KIND_STAT) begin
         for (int unsigned s = 0; s < DBM_NSETS; s++)
            if (set_hit[s]) bus_rdata = status[s];
      end
   end

   assign bus_ready = bus_sel;
   assign bus_err   = bus_sel & blocked;
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker
   import dbm_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_SEC  = 'h200,
   parameter int unsigned TX_STRIDE = 'h100,
   parameter int unsigned WIN       = 'h20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               bus_secure,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               bus_ready,
   input logic               bus_err,
   input logic [DBM_NCH-1:0] irq_rx,
   input logic [DBM_NCH-1:0] irq_tx
);
   logic sec_win, any_wr, ns_sec;
   assign sec_win = (int'(bus_addr) >= BASE_SEC && int'(bus_addr) < BASE_SEC + WIN) ||
                    (int'(bus_addr) >= BASE_SEC + TX_STRIDE &&
                     int'(bus_addr) < BASE_SEC + TX_STRIDE + WIN);
   assign any_wr  = bus_sel & bus_wr;
   assign ns_sec  = bus_sel & ~bus_secure & sec_win;

   for (genvar c = 0; c < DBM_NCH; c++) begin : g_ch
      AST_RX_RISE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_rx[c]) |-> $past(any_wr)); // R2
      AST_TX_RISE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_tx[c]) |-> $past(any_wr)); // R2
      AST_RX_FALL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_rx[c]) |-> $past(any_wr)); // R3
   end

   AST_ZERO_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && bus_wdata == '0) |=> ($stable(irq_rx) && $stable(irq_tx))); // R3

   AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (bus_addr[4:0] == 5'h08 || bus_addr[4:0] == 5'h10))
      |-> bus_rdata == '0); // R4

   AST_NS_SECURE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      ns_sec |-> (bus_err && bus_rdata == '0)); // R8

   AST_NS_SECURE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (ns_sec && bus_wr) |=> ($stable(irq_rx[DBM_SECCH]) && $stable(irq_tx[DBM_SECCH]))); // R8

   AST_ERR_ONLY_NS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (!bus_secure && sec_win)); // R9

   AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_ready); // R10
endmodule

bind dbell_mbox dbm_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .BASE_SEC (BASE_SEC),
   .TX_STRIDE(TX_STRIDE),
   .WIN      (WIN)
) u_dbm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_secure(bus_secure),
   .bus_rdata (bus_rdata),
   .bus_ready (bus_ready),
   .bus_err   (bus_err),
   .irq_rx    (irq_rx),
   .irq_tx    (irq_tx)
);

// File: tb/dbell_mbox_bench.sv
module dbell_mbox_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_secure = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        bus_err;
   logic [2:0]  irq_rx;
   logic [2:0]  irq_tx;

   int checks = 0;
   int fails  = 0;
   logic [31:0] m_stat [6];
   bit done = 1'b0;

   always #4 clk = ~clk;

   dbell_mbox u_dbell_mbox (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
      .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Model decode: kind 0 none, 1 status, 2 set, 3 clear
   task automatic mdec(input int a, input bit sec, output int idx, output int kind, output bit blk);
      idx = 0; kind = 0; blk = 1'b0;
      for (int ch = 0; ch < 3; ch++) begin
         for (int dir = 0; dir < 2; dir++) begin
            int b;
            b = (ch == 0) ? 'h000 : (ch == 1) ? 'h020 : 'h200;
            b = b + dir * 'h100;
            if (a == b)      begin kind = 1; idx = ch*2 + dir; end
            if (a == b + 8)  begin kind = 2; idx = ch*2 + dir; end
            if (a == b + 16) begin kind = 3; idx = ch*2 + dir; end
            if (ch == 2 && !sec && a >= b && a < b + 32) blk = 1'b1;
         end
      end
      if (blk) kind = 0;
   endtask

   task automatic acc(input bit wr, input int a, input logic [31:0] d, input bit sec, input string tag);
      int idx, kind;
      bit blk;
      logic [31:0] exp_rd;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a[11:0]; bus_wdata = d; bus_secure = sec;
      #1;
      mdec(a, sec, idx, kind, blk);
      exp_rd = (!wr && kind == 1) ? m_stat[idx] : 32'h0;
      chk(bus_rdata == exp_rd, {tag, " rdata"}, bus_rdata, exp_rd);
      chk(bus_err == blk, {tag, " err"}, {31'h0, bus_err}, {31'h0, blk});
      chk(bus_ready == 1'b1, "R10 ready", {31'h0, bus_ready}, 32'h1);
      @(posedge clk);
      if (wr && kind == 2) m_stat[idx] = m_stat[idx] | d;
      if (wr && kind == 3) m_stat[idx] = m_stat[idx] & ~d;
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_exp(input int a, input bit sec, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[11:0]; bus_secure = sec;
      #1;
      chk(bus_rdata == exp, tag, bus_rdata, exp);
      @(posedge clk);
      #1;
      bus_sel = 1'b0;
   endtask

   // Per-clock comparison of interrupts and idle outputs (R5, R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #2;
         for (int c = 0; c < 3; c++) begin
            chk(irq_rx[c] == (m_stat[2*c] != 0), "R5 irq_rx", {31'h0, irq_rx[c]}, {31'h0, m_stat[2*c] != 0});
            chk(irq_tx[c] == (m_stat[2*c+1] != 0), "R5 irq_tx", {31'h0, irq_tx[c]}, {31'h0, m_stat[2*c+1] != 0});
         end
         if (!bus_sel) chk(bus_ready == 1'b0, "R10 idle ready", {31'h0, bus_ready}, 32'h0);
      end
   end

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int s = 0; s < 6; s++) m_stat[s] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk(irq_rx == 3'b0 && irq_tx == 3'b0, "R1 irqs", {26'h0, irq_rx, irq_tx}, 32'h0);
      rd_exp('h000, 1, 0, "R1 lp rx");
      rd_exp('h120, 1, 0, "R1 hp tx");
      rd_exp('h300, 1, 0, "R1 sec tx");

      // R2: set ORs in ones only
      acc(1, 'h008, 32'h0000_00F0, 0, "R2 set");
      rd_exp('h000, 0, 32'h0000_00F0, "R2 after set");
      acc(1, 'h008, 32'h0000_0F00, 0, "R2 set more");
      rd_exp('h000, 0, 32'h0000_0FF0, "R2 zeros keep");

      // R4: set/clear read zero
      acc(0, 'h008, 0, 0, "R4 set read");
      acc(0, 'h010, 0, 0, "R4 clr read");
      rd_exp('h010, 0, 0, "R4 clr explicit");

      // R3: clear ones only; zero write is no-op
      acc(1, 'h010, 32'h0000_0030, 0, "R3 clear");
      rd_exp('h000, 0, 32'h0000_0FC0, "R3 after clear");
      acc(1, 'h010, 32'h0, 0, "R3 clear zero");
      rd_exp('h000, 0, 32'h0000_0FC0, "R3 zero write");

      // R6: address map, distinct pattern per word
      acc(1, 'h028, 32'h0000_0002, 0, "R6 hp rx set");
      acc(1, 'h108, 32'h0000_0004, 0, "R6 lp tx set");
      acc(1, 'h128, 32'h8000_0000, 0, "R6 hp tx set");
      acc(1, 'h208, 32'h0001_0000, 1, "R9 sec rx set");
      acc(1, 'h308, 32'h0100_0000, 1, "R9 sec tx set");
      rd_exp('h020, 0, 32'h0000_0002, "R6 hp rx");
      rd_exp('h100, 0, 32'h0000_0004, "R6 lp tx");
      rd_exp('h120, 0, 32'h8000_0000, "R6 hp tx");
      rd_exp('h200, 1, 32'h0001_0000, "R9 sec rx");
      rd_exp('h300, 1, 32'h0100_0000, "R9 sec tx");

      // R5: receiver handshake clears one word only
      acc(0, 'h120, 0, 0, "R5 recv read");
      acc(1, 'h130, 32'h8000_0000, 0, "R5 recv clear");
      rd_exp('h120, 0, 32'h0, "R5 sender sees done");
      @(negedge clk); #2;
      chk(irq_tx[1] == 1'b0 && irq_rx[1] == 1'b1, "R5 independent", {30'h0, irq_tx[1], irq_rx[1]}, 32'h1);

      // R7: unmapped addresses
      acc(1, 'h004, 32'hFFFF_FFFF, 0, "R7 hole wr");
      acc(1, 'h040, 32'hFFFF_FFFF, 1, "R7 gap wr");
      acc(1, 'h400, 32'hFFFF_FFFF, 1, "R7 high wr");
      acc(1, 'h214, 32'hFFFF_FFFF, 1, "R7 sec hole wr");
      acc(0, 'h00C, 0, 0, "R7 hole rd");
      rd_exp('h000, 0, 32'h0000_0FC0, "R7 lp rx kept");
      rd_exp('h020, 0, 32'h0000_0002, "R7 hp rx kept");

      // R8: non-secure refused on secure windows
      acc(1, 'h208, 32'h0000_00FF, 0, "R8 ns set");
      acc(1, 'h210, 32'hFFFF_FFFF, 0, "R8 ns clr");
      acc(1, 'h310, 32'hFFFF_FFFF, 0, "R8 ns tx clr");
      acc(0, 'h200, 0, 0, "R8 ns rd");
      acc(0, 'h31C, 0, 0, "R8 ns hole rd");
      rd_exp('h200, 1, 32'h0001_0000, "R8 sec rx unchanged");
      rd_exp('h300, 1, 32'h0100_0000, "R8 sec tx unchanged");

      // R9: secure clears its channel
      acc(1, 'h210, 32'h0001_0000, 1, "R9 sec clr");
      rd_exp('h200, 1, 32'h0, "R9 sec rx cleared");

      // mixed patterns across all words
      v = 32'h1357_9BDF;
      for (int i = 0; i < 60; i++) begin
         int ch, dir, op, a;
         v = {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
         ch = int'(v[3:0]) % 3; dir = int'(v[4]); op = int'(v[6:5]) % 3;
         a = ((ch == 0) ? 'h000 : (ch == 1) ? 'h020 : 'h200) + dir * 'h100 + op * 8;
         acc(v[7] | (op == 0 ? 1'b0 : 1'b1), a, v, v[8], "R6 mixed");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule